// File: doc/BRIEF.md
# DDR2 Low-Power State Sequencer

This block sits beside a DDR2 memory controller's command scheduler. It owns the memory clock-enable line and takes over the command bus whenever the memory enters or leaves a low-power state. Two state requests come in as level bits. One asks for self-refresh. The other asks for precharge power-down. The block acts on either only while no access is pending. If any bank is still open, it first closes all banks with a precharge-all command, waits tRP, and then drops clock-enable. On the self-refresh path it issues an auto-refresh in the same cycle that clock-enable falls.

Either state is left when an access request arrives, or when the requesting bit is cleared. Leaving self-refresh takes a fixed sequence. Clock-enable rises, the block waits tXSNR, issues one auto-refresh, and waits tRFC. It then activates the row for the held access and pulses `acc_rdy`. A read additionally waits until tXSRD has passed since clock-enable rose. On-die termination is held off over that same window. Leaving power-down raises clock-enable, waits tXP, and activates at once, with no refresh.

All delays are cycle counts given on input ports. While the memory is in self-refresh or on its way out, `sr_busy` is high, so software can poll it before it issues an access.

Top module: `ddr2_lowpower_seq`

## Requirements
- R1: With the block idle and `acc_req` high, `mem_cmd` is ACTIVATE and `acc_rdy` is high in that same cycle. `acc_rdy` is only ever high together with `acc_req`. The command encoding is NOP=0, PRECHARGE ALL=1, AUTO REFRESH=2, ACTIVATE=3.
- R2: With the block idle, no access pending and `sleep_req` high, entry to self-refresh takes one of two paths. If no bank is open, AUTO REFRESH is issued with `mem_cke` low in that same cycle. If `banks_open` is high, PRECHARGE ALL is issued first, and the AUTO REFRESH with `mem_cke` falling follows exactly `t_rp` cycles later.
- R3: With the block idle, no access pending and `cke_off` high, entry to power-down also has two paths. With banks open, PRECHARGE ALL is issued and `mem_cke` falls exactly `t_rp` cycles later. With no bank open, `mem_cke` falls at once. No AUTO REFRESH is issued on this path.
- R4: `mem_cke` stays low for at least `t_cke` cycles. When a wake-up condition is already present, `mem_cke` rises exactly `t_cke` cycles after it fell (for `t_cke` of 2 or more).
- R5: Self-refresh is left on `acc_req` or when `sleep_req` is cleared. `mem_cke` rises first, and AUTO REFRESH follows exactly `t_xsnr` cycles later.
- R6: For a write wake-up, ACTIVATE and `acc_rdy` come exactly `t_rfc` cycles after that AUTO REFRESH. The same holds for a read wake-up when tXSRD is already met by then.
- R7: For a read wake-up, ACTIVATE and `acc_rdy` come at the later of two cycles: `t_rfc` after the AUTO REFRESH, and `t_xsrd` after `mem_cke` rose.
- R8: `mem_odt` is low whenever `mem_cke` is low. After a self-refresh exit it stays low until `t_xsrd` cycles after `mem_cke` rose, and it follows `odt_req` from that cycle on. After a power-down exit it follows `odt_req` from the cycle `mem_cke` rises.
- R9: `sr_busy` goes high in the cycle after self-refresh entry. It stays high through the exit sequence. When the exit is caused by clearing `sleep_req` with no access pending, the block returns to idle one cycle after `t_rfc` expires, with no ACTIVATE and no `acc_rdy`.
- R10: Power-down is left on `acc_req` or when `cke_off` is cleared. `mem_cke` rises, and `t_xp` cycles later either ACTIVATE with `acc_rdy` is issued, or the block goes idle with no command if no access is pending.
- R11: An access that arrives during the tRP wait of an entry cancels the entry. ACTIVATE and `acc_rdy` are issued when tRP expires, and `mem_cke` never falls.
- R12: In every cycle not named above, `mem_cmd` is NOP. In particular, it is NOP in every cycle with `mem_cke` low except the entry cycle.
- R13: Out of reset `mem_cke` is high, `mem_cmd` is NOP, and `acc_rdy`, `sr_busy` and `mem_odt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Pending access, held until `acc_rdy` |
| acc_rd | input | 1 | Pending access is a read |
| sleep_req | input | 1 | Request self-refresh; clearing it wakes the memory |
| cke_off | input | 1 | Request precharge power-down; clearing it wakes the memory |
| banks_open | input | 1 | At least one bank is open |
| odt_req | input | 1 | Termination wanted by the scheduler |
| t_xsnr | input | TW | Clock-enable rise to first command after self-refresh |
| t_rfc | input | TW | Auto-refresh to activate |
| t_xsrd | input | TW | Clock-enable rise to read after self-refresh |
| t_rp | input | TW | Precharge to low-power entry |
| t_cke | input | TW | Minimum clock-enable low time |
| t_xp | input | TW | Clock-enable rise to activate after power-down |
| mem_cmd | output | 2 | Command: 0 NOP, 1 PRECHARGE ALL, 2 AUTO REFRESH, 3 ACTIVATE |
| mem_cke | output | 1 | Memory clock-enable |
| mem_odt | output | 1 | Memory on-die termination |
| sr_busy | output | 1 | Self-refresh active or being left |
| acc_rdy | output | 1 | One-cycle release of the held access |

## Verification
The assertions take several things for granted about the inputs. The timing inputs stay constant whenever the block is not idle. `t_xsnr`, `t_xp`, `t_rp` and `t_rfc` are at least 1. `acc_req` is held until `acc_rdy` and dropped right after it, with `acc_rd` steady for as long as `acc_req` is high. The stimulus keeps to this in three ways. The delays are fixed per scenario, and each change is made between scenarios while the block is idle. Request and state bits change only just after a clock edge. The request is withdrawn in the cycle that follows the observed ready pulse.

// File: rtl/ddr2_lowpower_seq.sv
module ddr2_lowpower_seq #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_req,
  input  logic          acc_rd,
  input  logic          sleep_req,
  input  logic          cke_off,
  input  logic          banks_open,
  input  logic          odt_req,
  input  logic [TW-1:0] t_xsnr,
  input  logic [TW-1:0] t_rfc,
  input  logic [TW-1:0] t_xsrd,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_cke,
  input  logic [TW-1:0] t_xp,
  output logic [1:0]    mem_cmd,
  output logic          mem_cke,
  output logic          mem_odt,
  output logic          sr_busy,
  output logic          acc_rdy
);

  localparam logic [1:0] C_NOP = 2'd0;
  localparam logic [1:0] C_PRE = 2'd1;
  localparam logic [1:0] C_REF = 2'd2;
  localparam logic [1:0] C_ACT = 2'd3;
  localparam logic [TW-1:0] ONE = TW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_RP, S_SR, S_XSNR, S_RFC, S_XSRD, S_PD, S_XP
  } st_t;

  st_t st, st_n;
  logic [TW-1:0] cnt, cnt_n;
  logic [TW-1:0] xcnt;
  logic to_sr, to_sr_n;
  logic xhold;
  logic cke_drop;

  wire cnt_z    = (cnt == '0);
  wire may_exit = (cnt <= ONE);
  wire xs_met   = (xcnt >= t_xsrd);
  wire wake_sr  = acc_req | ~sleep_req;
  wire wake_pd  = acc_req | ~cke_off;

  always_comb begin
    st_n     = st;
    cnt_n    = cnt_z ? cnt : cnt - ONE;
    to_sr_n  = to_sr;
    mem_cmd  = C_NOP;
    acc_rdy  = 1'b0;
    cke_drop = 1'b0;
    case (st)
      S_IDLE:
        if (acc_req) begin
          mem_cmd = C_ACT;
          acc_rdy = 1'b1;
        end else if (sleep_req || cke_off) begin
          to_sr_n = sleep_req;
          if (banks_open) begin
            mem_cmd = C_PRE;
            st_n    = S_RP;
            cnt_n   = t_rp - ONE;
          end else begin
            cke_drop = 1'b1;
            mem_cmd  = sleep_req ? C_REF : C_NOP;
            st_n     = sleep_req ? S_SR : S_PD;
            cnt_n    = t_cke - ONE;
          end
        end
      S_RP:
        if (cnt_z) begin
          if (acc_req) begin
            mem_cmd = C_ACT;
            acc_rdy = 1'b1;
            st_n    = S_IDLE;
          end else begin
            cke_drop = 1'b1;
            mem_cmd  = to_sr ? C_REF : C_NOP;
            st_n     = to_sr ? S_SR : S_PD;
            cnt_n    = t_cke - ONE;
          end
        end
      S_SR:
        if (may_exit && wake_sr) begin
          st_n  = S_XSNR;
          cnt_n = t_xsnr;
        end
      S_XSNR:
        if (cnt_z) begin
          mem_cmd = C_REF;
          st_n    = S_RFC;
          cnt_n   = t_rfc - ONE;
        end
      S_RFC:
        if (cnt_z) begin
          if (!acc_req) begin
            st_n = S_IDLE;
          end else if (acc_rd && !xs_met) begin
            st_n = S_XSRD;
          end else begin
            mem_cmd = C_ACT;
            acc_rdy = 1'b1;
            st_n    = S_IDLE;
          end
        end
      S_XSRD:
        if (!acc_req) begin
          st_n = S_IDLE;
        end else if (xs_met) begin
          mem_cmd = C_ACT;
          acc_rdy = 1'b1;
          st_n    = S_IDLE;
        end
      S_PD:
        if (may_exit && wake_pd) begin
          st_n  = S_XP;
          cnt_n = t_xp;
        end
      S_XP:
        if (cnt_z) begin
          if (acc_req) begin
            mem_cmd = C_ACT;
            acc_rdy = 1'b1;
          end
          st_n = S_IDLE;
        end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      to_sr <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      to_sr <= to_sr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xhold <= 1'b0;
      xcnt  <= '0;
    end else if (st == S_SR && st_n == S_XSNR) begin
      xhold <= 1'b1;
      xcnt  <= '0;
    end else if (xhold) begin
      if (xs_met) xhold <= 1'b0;
      else        xcnt  <= xcnt + ONE;
    end
  end

  assign mem_cke = !(st == S_SR || st == S_PD || cke_drop);
  assign mem_odt = odt_req & mem_cke & ~(xhold & ~xs_met);
  assign sr_busy = (st == S_SR) || (st == S_XSNR) || (st == S_RFC) || (st == S_XSRD);

  logic [TW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (mem_cke)        low_run <= '0;
    else if (low_run != '1)  low_run <= low_run + ONE;
  end

  // R1
  rdy_is_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdy |-> (mem_cmd == C_ACT));

  // R1
  rdy_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rdy |-> acc_req);

  // R8
  odt_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> !mem_odt);

  // R4
  cke_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> (low_run >= t_cke));

  // R5
  wake_cycle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> (mem_cmd == C_NOP));

  // R12
  asleep_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cke && !$fell(mem_cke)) |-> (mem_cmd == C_NOP));

endmodule

// File: tb/ddr2_lowpower_seq_test.sv
module ddr2_lowpower_seq_test;
  localparam int TW = 8;
  localparam int TXSNR = 4, TRFC = 6, TRP = 3, TCKE = 5, TXP = 2;

  logic clk = 0, rst_n = 0;
  logic acc_req = 0, acc_rd = 0, sleep_req = 0, cke_off = 0, banks_open = 0, odt_req = 0;
  logic [TW-1:0] t_xsnr = TXSNR, t_rfc = TRFC, t_xsrd = 20, t_rp = TRP, t_cke = TCKE, t_xp = TXP;
  logic [1:0] mem_cmd;
  logic mem_cke, mem_odt, sr_busy, acc_rdy;

  ddr2_lowpower_seq #(.TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_rd(acc_rd),
    .sleep_req(sleep_req), .cke_off(cke_off), .banks_open(banks_open), .odt_req(odt_req),
    .t_xsnr(t_xsnr), .t_rfc(t_rfc), .t_xsrd(t_xsrd), .t_rp(t_rp), .t_cke(t_cke), .t_xp(t_xp),
    .mem_cmd(mem_cmd), .mem_cke(mem_cke), .mem_odt(mem_odt), .sr_busy(sr_busy), .acc_rdy(acc_rdy));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int t_rise, t_fall, t_ref0, t_ref, t_pre, t_act, t_odt, t_sron, t_sroff;
  int n_rdy, n_ref, n_cmd;

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic run(input int n, input int rq_at, input bit rd,
                     input int sl_on, input int sl_off, input int pd_on, input int pd_off);
    bit drop = 0;
    logic pcke = mem_cke, podt = mem_odt, psr = sr_busy;
    t_rise = -1; t_fall = -1; t_ref0 = -1; t_ref = -1; t_pre = -1; t_act = -1;
    t_odt = -1; t_sron = -1; t_sroff = -1; n_rdy = 0; n_ref = 0; n_cmd = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (drop) begin acc_req = 0; drop = 0; end
      if (i == rq_at) begin acc_req = 1; acc_rd = rd; end
      if (i == sl_on) sleep_req = 1;
      if (i == sl_off) sleep_req = 0;
      if (i == pd_on) cke_off = 1;
      if (i == pd_off) cke_off = 0;
      @(negedge clk);
      if (acc_rdy) begin n_rdy++; drop = 1; end
      if (mem_cmd != 2'd0) n_cmd++;
      if (mem_cmd == 2'd2) begin n_ref++; if (t_ref0 < 0) t_ref0 = i; t_ref = i; end
      if (mem_cmd == 2'd1 && t_pre < 0) t_pre = i;
      if (mem_cmd == 2'd3) t_act = i;
      if (!mem_cke && pcke && t_fall < 0) t_fall = i;
      if (mem_cke && !pcke && t_rise < 0) t_rise = i;
      if (mem_odt && !podt && t_odt < 0) t_odt = i;
      if (sr_busy && !psr && t_sron < 0) t_sron = i;
      if (!sr_busy && psr && t_sroff < 0) t_sroff = i;
      pcke = mem_cke; podt = mem_odt; psr = sr_busy;
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R13 cke", mem_cke, 1);
    chk("R13 cmd", mem_cmd, 0);
    chk("R13 rdy", acc_rdy, 0);
    chk("R13 busy", sr_busy, 0);
    chk("R13 odt", mem_odt, 0);
  endtask

  task automatic test_idle_access();
    run(4, 0, 0, -1, -1, -1, -1);
    chk("R1 act cycle", t_act, 0);
    chk("R1 rdy count", n_rdy, 1);
    chk("R1 cke stays", t_fall, -1);
  endtask

  task automatic test_sr_write();
    banks_open = 0;
    run(30, 2, 0, 0, 2, -1, -1);
    chk("R2 ref at entry", t_ref0, 0);
    chk("R2 cke fall", t_fall, 0);
    chk("R9 busy on", t_sron, 1);
    chk("R4 low time", t_rise - t_fall, TCKE);
    chk("R5 xsnr", t_ref - t_rise, TXSNR);
    chk("R6 rfc", t_act - t_ref, TRFC);
    chk("R6 rdy", n_rdy, 1);
    chk("R12 cmd count", n_cmd, 3);
    chk("R9 busy off", t_sroff, t_act + 1);
    chk("R8 odt hold", t_odt - t_rise, 20);
  endtask

  task automatic test_sr_read(input int xsrd);
    int exp_act;
    t_xsrd = xsrd[TW-1:0];
    run(32, 2, 1, 0, 2, -1, -1);
    exp_act = (t_ref + TRFC > t_rise + xsrd) ? t_ref + TRFC : t_rise + xsrd;
    chk("R7 read act", t_act, exp_act);
    chk("R7 read rdy", n_rdy, 1);
    chk("R8 odt read", t_odt - t_rise, xsrd);
    t_xsrd = 20;
    acc_rd = 0;
  endtask

  task automatic test_sr_ctl_exit();
    run(22, -1, 0, 0, 3, -1, -1);
    chk("R5 ctl xsnr", t_ref - t_rise, TXSNR);
    chk("R9 idle return", t_sroff - t_ref, TRFC + 1);
    chk("R9 no act", t_act, -1);
    chk("R9 no rdy", n_rdy, 0);
  endtask

  task automatic test_pd_banks();
    banks_open = 1;
    run(16, 8, 0, -1, -1, 0, 8);
    chk("R3 pre", t_pre, 0);
    chk("R3 fall", t_fall, TRP);
    chk("R3 no ref", n_ref, 0);
    chk("R10 xp act", t_act - t_rise, TXP);
    chk("R10 rdy", n_rdy, 1);
    banks_open = 0;
  endtask

  task automatic test_sr_banks();
    banks_open = 1;
    run(24, -1, 0, 0, 6, -1, -1);
    chk("R2 pre first", t_pre, 0);
    chk("R2 ref after rp", t_ref0, TRP);
    chk("R2 fall with ref", t_fall, TRP);
    chk("R4 early wake", t_rise - t_fall, TCKE);
    banks_open = 0;
  endtask

  task automatic test_rp_abort();
    banks_open = 1;
    run(8, 1, 0, -1, -1, 0, 1);
    chk("R11 act", t_act, TRP);
    chk("R11 no fall", t_fall, -1);
    chk("R11 rdy", n_rdy, 1);
    banks_open = 0;
  endtask

  task automatic test_pd_ctl_exit();
    run(14, -1, 0, -1, -1, 0, 7);
    chk("R3 immediate fall", t_fall, 0);
    chk("R10 rise", t_rise, 8);
    chk("R10 no cmd", n_cmd, 0);
    chk("R10 no rdy", n_rdy, 0);
    chk("R8 pd odt", t_odt, t_rise);
  endtask

  task automatic test_pd_tcke();
    run(10, 1, 0, -1, -1, 0, 1);
    chk("R4 exact tcke", t_rise - t_fall, TCKE);
    chk("R10 act after xp", t_act, t_rise + TXP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    test_reset();
    odt_req = 1;
    test_idle_access();
    test_sr_write();
    test_sr_read(20);
    test_sr_read(8);
    test_sr_ctl_exit();
    test_pd_banks();
    test_sr_banks();
    test_rp_abort();
    test_pd_ctl_exit();
    test_pd_tcke();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule